// File: doc/BRIEF.md
# Parallel-Mode Flash Command Sequencer

This block is the device-side control logic of a small NOR-style flash array that a host reaches through a narrow parallel port. The address comes in two halves on one set of pins. A row/column select strobe separates them: its falling edge captures the lower half (bits 10..0) and its rising edge captures the upper half (bits 21..11). Each command byte is taken from the data pins when the write strobe rises, and it is paired with the address most recently assembled from the two halves.

The host unlocks the block with a protected sequence of writes before any change to the array. Four writes lead to a byte program and six writes lead to an erase of a sector, a block or the whole array. The block then runs a timed internal operation. While that operation runs, every further write is dropped and a read returns a status byte instead of array contents. When the block is idle, a read drives the addressed byte for as long as output-enable is low. The array is scaled down, and the sector size, block size and operation times are parameters.

Top module: `flash_cmd_seq`

## Requirements
- R1: The row half of the address is taken from `addr_i` on the falling edge of `rc_n` and the column half on its rising edge. The full address is {column, row}, and command addresses must match all 22 bits: 5555h is row 555h with column 00Ah, and 2AAAh is row 2AAh with column 005h.
- R2: The sequence AAh@5555h, 55h@2AAAh, A0h@5555h followed by (data, target) programs the byte. The new byte is the bitwise AND of the old byte and the data, so a program can only clear bits.
- R3: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh followed by 30h sets every byte to FFh in the sector (2^SECT_SHIFT bytes, default 16) that holds the sixth write's address. All other bytes keep their values.
- R4: The same five-write prefix followed by 50h sets every byte to FFh in the block (2^BLK_SHIFT bytes, default 64) that holds the sixth write's address. All other bytes keep their values.
- R5: The same prefix followed by 10h at address 5555h sets the whole array to FFh. The opcode 10h at any other address erases nothing.
- R6: A write that does not match the next expected step of a sequence returns the sequencer to idle, so a later write cannot complete the abandoned sequence.
- R7: Writes issued while an internal operation runs have no effect, including a complete program sequence.
- R8: While busy, a read with `oe_n` low returns a status byte. Bit 7 is the inverse of bit 7 of the byte being programmed, or 0 for an erase. Bit 6 flips on every falling edge of `oe_n`. Bits 5..0 are 0.
- R9: A program stays busy for PROG_CYC clocks and an erase for ERASE_CYC clocks, both counted from the write that starts it. After that, reads return array data again.
- R10: `dq_en` is high exactly while `oe_n` is low. When idle, `dq_o` then carries the byte at the latched address.
- R11: Driving `rst_n` low discards a partly entered sequence and aborts a running operation without changing the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the control logic |
| rc_n | input | 1 | Row/column select strobe |
| we_n | input | 1 | Write strobe, active low; the data byte is taken on its rise |
| oe_n | input | 1 | Output enable, active low |
| addr_i | input | 11 | Multiplexed address half |
| dq_i | input | 8 | Data from the host |
| dq_o | output | 8 | Data or status to the host |
| dq_en | output | 1 | High while `dq_o` should drive the shared data pins |

## Verification
The assertions assume that the strobes are synchronous to `clk`. They also assume that each strobe level is held for at least one clock, so that every edge is seen exactly once. The bench changes every pin on the falling clock edge and holds each strobe phase for a full clock, so each edge reaches the detectors exactly once. The bench also sets up the row half before `rc_n` falls and the column half before it rises, which is the ordering that R1 relies on. Status reads are placed well inside the busy window, and data reads come only after PROG_CYC or ERASE_CYC plus margin, so the bench never samples during the cycle in which the operation ends.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PRG,
        ST_ERA1,
        ST_ERA2,
        ST_ERA3,
        ST_BUSY
    } seq_st_e;

    typedef enum logic [1:0] {
        OP_PROG,
        OP_SECT,
        OP_BLK,
        OP_CHIP
    } op_e;

    localparam logic [15:0] CMD_ADDR_A = 16'h5555;
    localparam logic [15:0] CMD_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_1      = 8'hAA;
    localparam logic [7:0]  KEY_2      = 8'h55;
    localparam logic [7:0]  OPC_PROG   = 8'hA0;
    localparam logic [7:0]  OPC_ERASE  = 8'h80;
    localparam logic [7:0]  OPC_SECT   = 8'h30;
    localparam logic [7:0]  OPC_BLK    = 8'h50;
    localparam logic [7:0]  OPC_CHIP   = 8'h10;

endpackage

// File: rtl/flash_addr_latch.sv
module flash_addr_latch #(
    parameter int MUX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rc_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [MUX_W-1:0] addr_i,
    output logic [MUX_W-1:0] row_o,
    output logic [MUX_W-1:0] col_o,
    output logic             we_rise_o,
    output logic             oe_fall_o
);

    typedef struct packed {
        logic             rc;
        logic             we;
        logic             oe;
        logic [MUX_W-1:0] row;
        logic [MUX_W-1:0] col;
    } lat_t;

    lat_t q, d;
    logic rc_fall, rc_rise;

    always_comb begin
        d         = q;
        rc_fall   = q.rc & ~rc_n;
        rc_rise   = ~q.rc & rc_n;
        we_rise_o = ~q.we & we_n;
        oe_fall_o = q.oe & ~oe_n;
        d.rc      = rc_n;
        d.we      = we_n;
        d.oe      = oe_n;
        if (rc_fall) d.row = addr_i;
        if (rc_rise) d.col = addr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{rc: 1'b1, we: 1'b1, oe: 1'b1, row: '0, col: '0};
        end else begin
            q <= d;
        end
    end

    assign row_o = q.row;
    assign col_o = q.col;

    // R1: row half moves only after a falling select edge
    a_r1_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_fall |=> $stable(row_o));
    // R1: column half moves only after a rising select edge
    a_r1_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_rise |=> $stable(col_o));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int ARR_AW    = 8,
    parameter int PROG_CYC  = 24,
    parameter int ERASE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_rise,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              busy_o,
    output logic              fire_o,
    output op_e               op_o,
    output logic [ARR_AW-1:0] tgt_addr_o,
    output logic [7:0]        tgt_data_o
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_st_e           st;
        op_e               op;
        logic [CNT_W-1:0]  cnt;
        logic [ARR_AW-1:0] addr;
        logic [7:0]        data;
    } fsm_t;

    fsm_t q, d;
    logic hit_a, hit_b;

    always_comb begin
        d     = q;
        hit_a = (addr == ADDR_W'(CMD_ADDR_A));
        hit_b = (addr == ADDR_W'(CMD_ADDR_B));
        unique case (q.st)
            ST_IDLE: if (we_rise) d.st = (hit_a && data == KEY_1) ? ST_UNL1 : ST_IDLE;
            ST_UNL1: if (we_rise) d.st = (hit_b && data == KEY_2) ? ST_UNL2 : ST_IDLE;
            ST_UNL2: begin
                if (we_rise) begin
                    if (hit_a && data == OPC_PROG)       d.st = ST_PRG;
                    else if (hit_a && data == OPC_ERASE) d.st = ST_ERA1;
                    else                                 d.st = ST_IDLE;
                end
            end
            ST_PRG: begin
                if (we_rise) begin
                    d.st   = ST_BUSY;
                    d.op   = OP_PROG;
                    d.addr = addr[ARR_AW-1:0];
                    d.data = data;
                    d.cnt  = CNT_W'(PROG_CYC - 1);
                end
            end
            ST_ERA1: if (we_rise) d.st = (hit_a && data == KEY_1) ? ST_ERA2 : ST_IDLE;
            ST_ERA2: if (we_rise) d.st = (hit_b && data == KEY_2) ? ST_ERA3 : ST_IDLE;
            ST_ERA3: begin
                if (we_rise) begin
                    d.st   = ST_IDLE;
                    d.addr = addr[ARR_AW-1:0];
                    d.data = 8'h00;
                    d.cnt  = CNT_W'(ERASE_CYC - 1);
                    if (data == OPC_SECT) begin
                        d.st = ST_BUSY;
                        d.op = OP_SECT;
                    end else if (data == OPC_BLK) begin
                        d.st = ST_BUSY;
                        d.op = OP_BLK;
                    end else if (data == OPC_CHIP && hit_a) begin
                        d.st = ST_BUSY;
                        d.op = OP_CHIP;
                    end
                end
            end
            ST_BUSY: begin
                if (q.cnt == '0) d.st = ST_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_PROG, cnt: '0, addr: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st == ST_BUSY);
    assign fire_o     = (q.st == ST_BUSY) && (q.cnt == '0);
    assign op_o       = q.op;
    assign tgt_addr_o = q.addr;
    assign tgt_data_o = q.data;

    // R7: a running operation is not cut short by writes
    a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BUSY && q.cnt != '0) |=> (q.st == ST_BUSY && q.cnt == $past(q.cnt) - 1'b1));
    // R9: the operation ends the cycle after it is applied
    a_r9_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (q.st == ST_IDLE));
    // R9: the counter never exceeds the longest operation
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(q.cnt) < MAX_CYC));
    // R6: a wrong first write leaves the sequencer idle
    a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && we_rise && data != KEY_1) |=> (q.st == ST_IDLE));

endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_seq_pkg::*;
#(
    parameter int ARR_AW     = 8,
    parameter int SECT_SHIFT = 4,
    parameter int BLK_SHIFT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  op_e               op,
    input  logic [ARR_AW-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ARR_AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (fire) begin
                unique case (op)
                    OP_PROG: if (ARR_AW'(i) == tgt_addr) mem_d[i] = mem_q[i] & tgt_data;
                    OP_SECT: if ((ARR_AW'(i) >> SECT_SHIFT) == (tgt_addr >> SECT_SHIFT)) mem_d[i] = 8'hFF;
                    OP_BLK:  if ((ARR_AW'(i) >> BLK_SHIFT) == (tgt_addr >> BLK_SHIFT)) mem_d[i] = 8'hFF;
                    OP_CHIP: mem_d[i] = 8'hFF;
                    default: mem_d[i] = mem_q[i];
                endcase
            end
        end
    end

    // array contents survive reset, as non-volatile storage does
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];

    // R2: a program never turns a 0 bit into a 1
    a_r2_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_PROG) |=> ((mem_q[$past(tgt_addr)] & ~$past(mem_q[tgt_addr])) == 8'h00));
    // R5: a chip erase leaves both array ends erased
    a_r5_chip_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_CHIP) |=> (mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/flash_read_path.sv
module flash_read_path (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    input  logic       oe_n,
    input  logic       oe_fall,
    input  logic       poll_i,
    input  logic [7:0] rd_data,
    output logic [7:0] dq_o,
    output logic       dq_en
);

    typedef struct packed {
        logic toggle;
    } rd_t;

    rd_t q, d;

    always_comb begin
        d = q;
        if (busy_i && oe_fall) d.toggle = ~q.toggle;
        dq_en = ~oe_n;
        dq_o  = busy_i ? {poll_i, q.toggle, 6'b0} : rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{toggle: 1'b0};
        else        q <= d;
    end

    // R8: each read start while busy flips the toggle bit
    a_r8_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && oe_fall) |=> (q.toggle != $past(q.toggle)));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int MUX_W      = 11,
    parameter int ARR_AW     = 8,
    parameter int SECT_SHIFT = 4,
    parameter int BLK_SHIFT  = 6,
    parameter int PROG_CYC   = 24,
    parameter int ERASE_CYC  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rc_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [MUX_W-1:0] addr_i,
    input  logic [7:0]       dq_i,
    output logic [7:0]       dq_o,
    output logic             dq_en
);

    localparam int ADDR_W = 2 * MUX_W;

    logic [MUX_W-1:0]  row, col;
    logic [ADDR_W-1:0] full_addr;
    logic              we_rise, oe_fall;
    logic              busy, fire, poll;
    op_e               op;
    logic [ARR_AW-1:0] tgt_addr;
    logic [7:0]        tgt_data, rd_data;

    assign full_addr = {col, row};
    assign poll      = (op == OP_PROG) & ~tgt_data[7];

    flash_addr_latch #(.MUX_W(MUX_W)) lat_i (
        .clk(clk), .rst_n(rst_n), .rc_n(rc_n), .we_n(we_n), .oe_n(oe_n),
        .addr_i(addr_i), .row_o(row), .col_o(col),
        .we_rise_o(we_rise), .oe_fall_o(oe_fall)
    );

    flash_cmd_fsm #(
        .ADDR_W(ADDR_W), .ARR_AW(ARR_AW),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .we_rise(we_rise), .addr(full_addr),
        .data(dq_i), .busy_o(busy), .fire_o(fire), .op_o(op),
        .tgt_addr_o(tgt_addr), .tgt_data_o(tgt_data)
    );

    flash_array #(
        .ARR_AW(ARR_AW), .SECT_SHIFT(SECT_SHIFT), .BLK_SHIFT(BLK_SHIFT)
    ) arr_i (
        .clk(clk), .rst_n(rst_n), .fire(fire), .op(op),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .rd_addr(full_addr[ARR_AW-1:0]), .rd_data(rd_data)
    );

    flash_read_path rd_i (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .oe_n(oe_n),
        .oe_fall(oe_fall), .poll_i(poll), .rd_data(rd_data),
        .dq_o(dq_o), .dq_en(dq_en)
    );

    // R8: array data never leaks out while an operation runs
    a_r8_status_only: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !oe_n) |-> (dq_o[5:0] == 6'b0 && dq_o[7] == poll));

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;

    localparam int CLK_P     = 10;
    localparam int PROG_CYC  = 24;
    localparam int ERASE_CYC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rc_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr_i = '0;
    logic [7:0]  dq_i = '0;
    logic [7:0]  dq_o;
    logic        dq_en;

    int total = 0;
    int bad = 0;
    logic       smp_stb = 1'b0;
    logic [7:0] last_got;

    logic [7:0] exp_q [$];
    logic [7:0] msk_q [$];
    string      tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    flash_cmd_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .rc_n(rc_n), .we_n(we_n), .oe_n(oe_n),
        .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // monitor: pops one expected item per sample strobe
    always @(posedge clk) begin
        if (smp_stb) begin
            #1;
            last_got = dq_o;
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty", dq_o, 0);
            end else begin
                logic [7:0] e, m;
                string t;
                e = exp_q.pop_front();
                m = msk_q.pop_front();
                t = tag_q.pop_front();
                check(dq_en && ((dq_o & m) == (e & m)), t, dq_o & m, e & m);
            end
        end
    end

    task automatic set_addr(input logic [21:0] a);
        @(negedge clk); addr_i = a[10:0]; rc_n = 1'b0;
        @(negedge clk); addr_i = a[21:11]; rc_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [21:0] a, input logic [7:0] v);
        set_addr(a);
        @(negedge clk); dq_i = v; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
    endtask

    // driver: pushes the expected byte, then raises the sample strobe
    task automatic rd_exp(input logic [21:0] a, input logic [7:0] e,
                          input logic [7:0] m, input string tag);
        set_addr(a);
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk);
        exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(tag);
        smp_stb = 1'b1;
        @(negedge clk); smp_stb = 1'b0; oe_n = 1'b1;
    endtask

    task automatic unlock_prog(input logic [21:0] a, input logic [7:0] v);
        bus_wr(22'h5555, 8'hAA); bus_wr(22'h2AAA, 8'h55);
        bus_wr(22'h5555, 8'hA0); bus_wr(a, v);
    endtask

    task automatic erase_seq(input logic [21:0] a, input logic [7:0] opc);
        bus_wr(22'h5555, 8'hAA); bus_wr(22'h2AAA, 8'h55); bus_wr(22'h5555, 8'h80);
        bus_wr(22'h5555, 8'hAA); bus_wr(22'h2AAA, 8'h55); bus_wr(a, opc);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] s1;
        wait_cyc(3);
        check(dq_en == 1'b0, "R10 reset no drive", dq_en, 0);
        rst_n = 1'b1;
        wait_cyc(2);
        check(dq_en == 1'b0, "R10 oe high no drive", dq_en, 0);

        // chip erase with status polling
        erase_seq(22'h5555, 8'h10);
        rd_exp(22'h0, 8'h00, 8'hBF, "R8 erase status");
        s1 = last_got;
        rd_exp(22'h0, 8'h00, 8'hBF, "R8 erase status 2");
        check(s1[6] != last_got[6], "R8 toggle flips", last_got[6], ~s1[6]);
        wait_cyc(ERASE_CYC);
        rd_exp(22'h000, 8'hFF, 8'hFF, "R5 chip erase low");
        rd_exp(22'h0FF, 8'hFF, 8'hFF, "R5 chip erase high");

        // program and the bit-clearing rule
        unlock_prog(22'h012, 8'h5A);
        rd_exp(22'h012, 8'h80, 8'hBF, "R8 program status poll");
        wait_cyc(PROG_CYC);
        rd_exp(22'h012, 8'h5A, 8'hFF, "R2 program byte");
        unlock_prog(22'h012, 8'h0F);
        wait_cyc(PROG_CYC + 4);
        rd_exp(22'h012, 8'h0A, 8'hFF, "R2 program only clears");

        // R9 timing: the last write's rise is seen 1 clock after this task ends
        unlock_prog(22'h020, 8'hB3);
        wait_cyc(PROG_CYC - 10);
        rd_exp(22'h020, 8'h00, 8'hBF, "R9 still busy near end");
        wait_cyc(6);
        rd_exp(22'h020, 8'hB3, 8'hFF, "R9 done after PROG_CYC");

        // R3 sector erase
        unlock_prog(22'h030, 8'h11); wait_cyc(PROG_CYC + 2);
        unlock_prog(22'h04F, 8'h22); wait_cyc(PROG_CYC + 2);
        unlock_prog(22'h080, 8'h33); wait_cyc(PROG_CYC + 2);
        erase_seq(22'h035, 8'h30); wait_cyc(ERASE_CYC + 2);
        rd_exp(22'h030, 8'hFF, 8'hFF, "R3 sector erased");
        rd_exp(22'h012, 8'h0A, 8'hFF, "R3 other sector kept");
        rd_exp(22'h04F, 8'h22, 8'hFF, "R3 next sector kept");

        // R4 block erase
        erase_seq(22'h055, 8'h50); wait_cyc(ERASE_CYC + 2);
        rd_exp(22'h04F, 8'hFF, 8'hFF, "R4 block erased");
        rd_exp(22'h080, 8'h33, 8'hFF, "R4 next block kept");
        rd_exp(22'h012, 8'h0A, 8'hFF, "R4 prior block kept");

        // R5 chip opcode at the wrong address
        erase_seq(22'h1234, 8'h10); wait_cyc(ERASE_CYC + 2);
        rd_exp(22'h080, 8'h33, 8'hFF, "R5 chip erase needs 5555h");

        // R6 broken sequence
        bus_wr(22'h5555, 8'hAA); bus_wr(22'h2AAA, 8'h00);
        bus_wr(22'h2AAA, 8'h55); bus_wr(22'h5555, 8'hA0); bus_wr(22'h090, 8'h77);
        wait_cyc(PROG_CYC + 2);
        rd_exp(22'h090, 8'hFF, 8'hFF, "R6 mismatch aborts");

        // R1 column half must match too
        bus_wr(22'h5555 | 22'h200000, 8'hAA); bus_wr(22'h2AAA, 8'h55);
        bus_wr(22'h5555, 8'hA0); bus_wr(22'h091, 8'h00);
        wait_cyc(PROG_CYC + 2);
        rd_exp(22'h091, 8'hFF, 8'hFF, "R1 column half compared");
        unlock_prog(22'h092, 8'h3C); wait_cyc(PROG_CYC + 2);
        rd_exp(22'h092, 8'h3C, 8'hFF, "R1 row and column assembled");

        // R7 writes during an erase
        erase_seq(22'h0A0, 8'h30);
        unlock_prog(22'h0B0, 8'h00);
        wait_cyc(ERASE_CYC);
        rd_exp(22'h0B0, 8'hFF, 8'hFF, "R7 program during busy ignored");

        // R11 reset mid-sequence and during busy
        bus_wr(22'h5555, 8'hAA); bus_wr(22'h2AAA, 8'h55); bus_wr(22'h5555, 8'hA0);
        @(negedge clk); rst_n = 1'b0; wait_cyc(2); rst_n = 1'b1;
        bus_wr(22'h0C0, 8'h00); wait_cyc(PROG_CYC + 2);
        rd_exp(22'h0C0, 8'hFF, 8'hFF, "R11 partial sequence dropped");
        unlock_prog(22'h0C1, 8'h00); wait_cyc(3);
        rst_n = 1'b0; wait_cyc(2); rst_n = 1'b1;
        wait_cyc(PROG_CYC + 2);
        rd_exp(22'h0C1, 8'hFF, 8'hFF, "R11 busy operation aborted");

        // R10 idle read drives data, then releases
        rd_exp(22'h092, 8'h3C, 8'hFF, "R10 idle read");
        wait_cyc(1);
        check(dq_en == 1'b0, "R10 release after read", dq_en, 0);

        wait_cyc(4);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule